// File: doc/BRIEF.md
# Bottleneck Waiting-Cycle Tracker

This block is a small, fully associative table. It measures how much thread waiting each software-marked bottleneck causes. Cores report two kinds of event, each tagged with a bottleneck ID: a thread starting to wait, and a thread stopping waiting. Each live entry keeps a count of its current waiters. Every cycle, it adds that count to a saturating accumulator of waiting cycles.

Two consumers read the table. A lookup port asks whether a bottleneck should be shipped to a fast core: the answer is yes only when its accumulated count is strictly above a programmable threshold. A running port names the bottleneck that a small core is executing right now. When that bottleneck holds the largest count in the table, the block raises a preemption request addressed to that core.

Each entry is a two-state machine. It starts in ENT_EMPTY. The transition ALLOCATE moves it to ENT_LIVE, and that transition is taken when a new ID claims the entry. An entry in ENT_LIVE stays there through ACCUMULATE cycles. A later ALLOCATE with a different ID, taken on eviction, replaces it in place.

Top module: `wait_bottleneck_table`

## Requirements
- R1: After reset every entry is in ENT_EMPTY, and `accel_o`, `preempt_o` and `preempt_core_o` are 0.
- R2: A start-waiting event for a tracked ID raises that entry's waiter count by one, saturating at 2^WAIT_W-1. A stop-waiting event lowers it by one, stopping at 0. A stop-waiting event for an untracked ID has no effect.
- R3: Each cycle, every live entry adds its pre-update waiter count to its waiting-cycle count. That count saturates at 2^TWC_W-1 and never wraps.
- R4: A start-waiting event for an untracked ID allocates an entry with waiter count 1 and waiting-cycle count 0. It takes the lowest-index empty entry, so no ID is ever held twice.
- R5: When no entry is empty, the victim is the live entry with the smallest waiting-cycle count, with ties going to the lowest index.
- R6: One cycle after `lk_valid_i`, `accel_o` is 1 exactly when the ID is tracked and its waiting-cycle count, as it stood in the lookup cycle, is strictly greater than `thresh_i`.
- R7: A lookup of an untracked ID gives `accel_o` = 0 and allocates nothing.
- R8: A start-waiting event and a stop-waiting event for the same ID in the same cycle cancel: no waiter count changes and nothing is allocated.
- R9: One cycle after `run_valid_i`, `preempt_o` is 1 and `preempt_core_o` equals `run_core_i` exactly when all of the following hold in the request cycle: the running ID is tracked, its entry is the one with the highest waiting-cycle count (ties go to the lowest index), and that count is non-zero. Otherwise both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_valid_i | input | 1 | A thread started waiting |
| inc_id_i | input | ID_W | Bottleneck ID for the start-waiting event |
| dec_valid_i | input | 1 | A thread stopped waiting |
| dec_id_i | input | ID_W | Bottleneck ID for the stop-waiting event |
| lk_valid_i | input | 1 | Acceleration query |
| lk_id_i | input | ID_W | Bottleneck ID being queried |
| thresh_i | input | TWC_W | Acceleration threshold |
| run_valid_i | input | 1 | A small core reports its running bottleneck |
| run_id_i | input | ID_W | ID of the running bottleneck |
| run_core_i | input | CORE_W | Core executing it |
| accel_o | output | 1 | Registered acceleration decision |
| preempt_o | output | 1 | Registered preemption request |
| preempt_core_o | output | CORE_W | Core the preemption request is addressed to |

## Verification
The bench uses a four-entry table with narrow counters, so that evictions and both kinds of saturation happen often. One corner it targets is equal counts at eviction and at the maximum search. A design that broke ties by the highest index would evict the wrong ID and give the wrong preemption answer. It also sends start and stop events for the same ID in one cycle; a design that did not cancel them would drift the waiter count or allocate a spurious entry. Long high-waiter runs check that a counter which wrapped instead of saturating stops asserting acceleration. Lookups of IDs that are not tracked check that a lookup never allocates an entry.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
    typedef enum logic {
        ENT_EMPTY = 1'b0,
        ENT_LIVE  = 1'b1
    } ent_state_t;
endpackage

// File: rtl/wbt_entry.sv
module wbt_entry #(
    parameter int ID_W   = 16,
    parameter int WAIT_W = 6,
    parameter int TWC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ID_W-1:0]   alloc_tag_i,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic              live_o,
    output logic [ID_W-1:0]   tag_o,
    output logic [TWC_W-1:0]  twc_o
);
    import wbt_pkg::*;

    localparam logic [WAIT_W-1:0] WAIT_MAX = {WAIT_W{1'b1}};
    localparam logic [TWC_W-1:0]  TWC_MAX  = {TWC_W{1'b1}};

    ent_state_t        state_q, state_d;
    logic [ID_W-1:0]   tag_q, tag_d;
    logic [WAIT_W-1:0] waiters_q, waiters_d;
    logic [TWC_W-1:0]  twc_q, twc_d;
    logic [TWC_W:0]    twc_sum;

    assign twc_sum = {1'b0, twc_q} + {{(TWC_W+1-WAIT_W){1'b0}}, waiters_q};

    // Next-state process
    always_comb begin
        state_d   = state_q;
        tag_d     = tag_q;
        waiters_d = waiters_q;
        twc_d     = twc_q;
        unique case (state_q)
            ENT_EMPTY: begin
                if (alloc_i) begin          // ALLOCATE
                    state_d   = ENT_LIVE;
                    tag_d     = alloc_tag_i;
                    waiters_d = WAIT_W'(1);
                    twc_d     = '0;
                end
            end
            ENT_LIVE: begin
                if (alloc_i) begin          // ALLOCATE over a victim
                    tag_d     = alloc_tag_i;
                    waiters_d = WAIT_W'(1);
                    twc_d     = '0;
                end else begin              // ACCUMULATE
                    twc_d = twc_sum[TWC_W] ? TWC_MAX : twc_sum[TWC_W-1:0];
                    if (inc_i && !dec_i && waiters_q != WAIT_MAX)
                        waiters_d = waiters_q + WAIT_W'(1);
                    else if (dec_i && !inc_i && waiters_q != '0)
                        waiters_d = waiters_q - WAIT_W'(1);
                end
            end
            default: state_d = ENT_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ENT_EMPTY;
            tag_q     <= '0;
            waiters_q <= '0;
            twc_q     <= '0;
        end else begin
            state_q   <= state_d;
            tag_q     <= tag_d;
            waiters_q <= waiters_d;
            twc_q     <= twc_d;
        end
    end

    // Outputs
    always_comb begin
        live_o = (state_q == ENT_LIVE);
        tag_o  = tag_q;
        twc_o  = twc_q;
    end

    // R3: a live entry that was not replaced never loses waiting cycles
    a_r3_twc_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_LIVE && $past(state_q == ENT_LIVE) && !$past(alloc_i))
        |-> twc_q >= $past(twc_q));

    // R2: the waiter count moves by at most one per cycle
    a_r2_waiter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_LIVE && $past(state_q == ENT_LIVE) && !$past(alloc_i))
        |-> (waiters_q == $past(waiters_q)
             || waiters_q == WAIT_W'($past(waiters_q) + WAIT_W'(1))
             || waiters_q == WAIT_W'($past(waiters_q) - WAIT_W'(1))));
endmodule

// File: rtl/wbt_extreme_pick.sv
module wbt_extreme_pick #(
    parameter int N        = 32,
    parameter int W        = 24,
    parameter bit PICK_MAX = 1'b1,
    parameter int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][W-1:0] val_i,
    input  logic [N-1:0]        mask_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [W-1:0]        best_o
);
    // Strict comparison keeps the lowest index on ties
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (mask_i[i] && (!found_o ||
                (PICK_MAX ? (val_i[i] > best_o) : (val_i[i] < best_o)))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                best_o  = val_i[i];
            end
        end
    end
endmodule

// File: rtl/wait_bottleneck_table.sv
module wait_bottleneck_table #(
    parameter int ENTRIES = 32,
    parameter int ID_W    = 16,
    parameter int WAIT_W  = 6,
    parameter int TWC_W   = 24,
    parameter int CORE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_valid_i,
    input  logic [ID_W-1:0]   inc_id_i,
    input  logic              dec_valid_i,
    input  logic [ID_W-1:0]   dec_id_i,
    input  logic              lk_valid_i,
    input  logic [ID_W-1:0]   lk_id_i,
    input  logic [TWC_W-1:0]  thresh_i,
    input  logic              run_valid_i,
    input  logic [ID_W-1:0]   run_id_i,
    input  logic [CORE_W-1:0] run_core_i,
    output logic              accel_o,
    output logic              preempt_o,
    output logic [CORE_W-1:0] preempt_core_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             live;
    logic [ENTRIES-1:0][ID_W-1:0]   tags;
    logic [ENTRIES-1:0][TWC_W-1:0]  twcs;
    logic [ENTRIES-1:0]             inc_hit, dec_hit, lk_hit, run_hit, alloc_vec;

    logic             cancel, inc_eff, dec_eff;
    logic             any_free, need_alloc, alloc_go;
    logic [IDX_W-1:0] free_idx, alloc_idx, run_idx;
    logic [TWC_W-1:0] lk_twc, run_twc;

    logic             max_found, vic_found;
    logic [IDX_W-1:0] max_idx, vic_idx;
    logic [TWC_W-1:0] max_twc, vic_twc;

    assign cancel  = inc_valid_i && dec_valid_i && (inc_id_i == dec_id_i);
    assign inc_eff = inc_valid_i && !cancel;
    assign dec_eff = dec_valid_i && !cancel;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            inc_hit[i] = inc_eff && live[i] && (tags[i] == inc_id_i);
            dec_hit[i] = dec_eff && live[i] && (tags[i] == dec_id_i);
            lk_hit[i]  = live[i] && (tags[i] == lk_id_i);
            run_hit[i] = live[i] && (tags[i] == run_id_i);
        end
    end

    // Lowest-index empty entry, plus the lookup and running entry values
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        lk_twc   = '0;
        run_twc  = '0;
        run_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!live[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (lk_hit[i])  lk_twc = twcs[i];
            if (run_hit[i]) begin
                run_twc = twcs[i];
                run_idx = IDX_W'(i);
            end
        end
    end

    wbt_extreme_pick #(.N(ENTRIES), .W(TWC_W), .PICK_MAX(1'b1), .IDX_W(IDX_W)) u_max (
        .val_i(twcs), .mask_i(live),
        .found_o(max_found), .idx_o(max_idx), .best_o(max_twc)
    );

    wbt_extreme_pick #(.N(ENTRIES), .W(TWC_W), .PICK_MAX(1'b0), .IDX_W(IDX_W)) u_victim (
        .val_i(twcs), .mask_i(live),
        .found_o(vic_found), .idx_o(vic_idx), .best_o(vic_twc)
    );

    assign need_alloc = inc_eff && (inc_hit == '0);
    assign alloc_go   = need_alloc && (any_free || vic_found);
    assign alloc_idx  = any_free ? free_idx : vic_idx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            alloc_vec[i] = alloc_go && (alloc_idx == IDX_W'(i));
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        wbt_entry #(.ID_W(ID_W), .WAIT_W(WAIT_W), .TWC_W(TWC_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_vec[g]),
            .alloc_tag_i(inc_id_i),
            .inc_i      (inc_hit[g]),
            .dec_i      (dec_hit[g]),
            .live_o     (live[g]),
            .tag_o      (tags[g]),
            .twc_o      (twcs[g])
        );
    end

    // Registered decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accel_o        <= 1'b0;
            preempt_o      <= 1'b0;
            preempt_core_o <= '0;
        end else begin
            accel_o <= lk_valid_i && (lk_hit != '0) && (lk_twc > thresh_i);
            if (run_valid_i && (run_hit != '0) && max_found &&
                (run_idx == max_idx) && (run_twc != '0) && (vic_twc <= max_twc)) begin
                preempt_o      <= 1'b1;
                preempt_core_o <= run_core_i;
            end else begin
                preempt_o      <= 1'b0;
                preempt_core_o <= '0;
            end
        end
    end

    // R4: an ID is never held by two entries
    a_r4_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_hit));

    // R6: acceleration only answers a lookup
    a_r6_accel_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        accel_o |-> $past(lk_valid_i));

    // R9: preemption only answers a running report
    a_r9_preempt_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> $past(run_valid_i));

    // R9: the core field is quiet when no preemption is raised
    a_r9_core_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !preempt_o |-> preempt_core_o == '0);
endmodule

// File: tb/test_wait_bottleneck_table.sv
module test_wait_bottleneck_table;
    localparam int E = 4, IDW = 8, WW = 3, TW = 8, CW = 2;
    localparam int WMAX = 7, TMAX = 255;

    logic clk = 1'b0, rst_n = 1'b0;
    logic iv = 0, dv = 0, lv = 0, rv = 0;
    logic [IDW-1:0] iid = 0, did = 0, lid = 0, rid = 0;
    logic [TW-1:0] th = 0;
    logic [CW-1:0] rc = 0;
    logic accel, pre;
    logic [CW-1:0] pcore;

    int n_tests = 0, n_fail = 0;
    bit mv[E];
    int mtag[E], mw[E], mt[E];

    always #4 clk = ~clk;

    wait_bottleneck_table #(.ENTRIES(E), .ID_W(IDW), .WAIT_W(WW), .TWC_W(TW), .CORE_W(CW))
    i_wait_bottleneck_table (
        .clk(clk), .rst_n(rst_n),
        .inc_valid_i(iv), .inc_id_i(iid), .dec_valid_i(dv), .dec_id_i(did),
        .lk_valid_i(lv), .lk_id_i(lid), .thresh_i(th),
        .run_valid_i(rv), .run_id_i(rid), .run_core_i(rc),
        .accel_o(accel), .preempt_o(pre), .preempt_core_o(pcore)
    );

    function automatic int find(input int id);
        for (int i = 0; i < E; i++) if (mv[i] && mtag[i] == id) return i;
        return -1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, predict, compare after the edge
    task automatic step(input bit a_iv, input int a_iid, input bit a_dv, input int a_did,
                        input bit a_lv, input int a_lid, input int a_th,
                        input bit a_rv, input int a_rid, input int a_rc, input string tag);
        bit cn, ie, de, e_acc, e_pre;
        int ih, dh, lh, rh, maxi, slot, e_core;
        iv = a_iv; iid = IDW'(a_iid); dv = a_dv; did = IDW'(a_did);
        lv = a_lv; lid = IDW'(a_lid); th = TW'(a_th);
        rv = a_rv; rid = IDW'(a_rid); rc = CW'(a_rc);
        cn = a_iv && a_dv && a_iid == a_did;
        ie = a_iv && !cn; de = a_dv && !cn;
        lh = find(a_lid);
        e_acc = a_lv && lh >= 0 && mt[lh] > a_th;
        maxi = -1;
        for (int i = 0; i < E; i++) if (mv[i] && (maxi < 0 || mt[i] > mt[maxi])) maxi = i;
        rh = find(a_rid);
        e_pre = a_rv && rh >= 0 && rh == maxi && mt[rh] > 0;
        e_core = e_pre ? a_rc : 0;
        ih = find(a_iid); dh = find(a_did);
        slot = -1;
        if (ie && ih < 0) begin
            for (int i = E - 1; i >= 0; i--) if (!mv[i]) slot = i;
            if (slot < 0) begin
                slot = 0;
                for (int i = 1; i < E; i++) if (mt[i] < mt[slot]) slot = i;
            end
        end
        for (int i = 0; i < E; i++) begin
            if (i == slot) begin
                mv[i] = 1; mtag[i] = a_iid; mw[i] = 1; mt[i] = 0;
            end else if (mv[i]) begin
                mt[i] = (mt[i] + mw[i] > TMAX) ? TMAX : mt[i] + mw[i];
                if (ie && i == ih && mw[i] < WMAX) mw[i]++;
                if (de && i == dh && mw[i] > 0) mw[i]--;
            end
        end
        @(posedge clk); #2;
        check((tag == "") ? "R6" : tag, int'(accel), int'(e_acc));
        check((tag == "") ? "R9" : tag, int'(pre), int'(e_pre));
        check("R9", int'(pcore), e_core);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0,0,0,0,0,0,0,0,0,0,"R3");
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < E; i++) begin mv[i] = 0; mtag[i] = 0; mw[i] = 0; mt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", int'(accel), 0); check("R1", int'(pre), 0); check("R1", int'(pcore), 0);
        @(negedge clk);
        // R7: lookup of an absent ID, then confirm nothing was allocated
        step(0,0,0,0,1,9,0,1,9,1,"R7");
        step(0,0,0,0,1,9,0,1,9,1,"R7");
        // R2/R4: allocate ID 1, add waiters, remove one
        step(1,1,0,0,0,0,0,0,0,0,"R4");
        step(1,1,0,0,0,0,0,0,0,0,"R2");
        step(0,0,1,1,1,1,0,1,1,2,"R2");
        step(0,0,1,5,1,1,2,1,1,3,"R2");
        // R8: same-ID start and stop cancel, also for an absent ID
        step(1,1,1,1,1,1,4,0,0,0,"R8");
        step(1,7,1,7,1,7,0,1,7,1,"R8");
        // R5: equal-count entries, eviction picks lowest index
        step(1,2,0,0,0,0,0,0,0,0,"R4");
        step(1,3,1,2,0,0,0,0,0,0,"R5");
        step(1,4,1,3,0,0,0,0,0,0,"R5");
        step(0,0,1,4,1,2,0,1,1,0,"R5");
        idle(3);
        step(1,6,0,0,1,2,0,1,3,1,"R5");
        step(1,8,0,0,1,3,0,1,4,2,"R5");
        step(0,0,0,0,1,1,0,1,1,3,"R5");
        // R3: saturation of the waiting-cycle count
        for (int k = 0; k < 8; k++) step(1,1,0,0,0,0,0,0,0,0,"R2");
        idle(45);
        step(0,0,0,0,1,1,254,1,1,1,"R3");
        idle(10);
        step(0,0,0,0,1,1,254,1,1,2,"R3");
        // Random traffic over a small ID space
        for (int k = 0; k < 4000; k++) begin
            step($urandom_range(0,1), $urandom_range(0,6), $urandom_range(0,1),
                 $urandom_range(0,6), $urandom_range(0,1), $urandom_range(0,7),
                 $urandom_range(0,255), $urandom_range(0,1), $urandom_range(0,7),
                 $urandom_range(0,3), "");
            if (k % 700 == 699) begin
                for (int j = 0; j < 12; j++) step(0,0,1,j % 7,0,0,0,0,0,0,"R2");
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule